// File: doc/BRIEF.md
# Exception Entry and Interrupt Masking Unit

This block is the interrupt-acceptance slice of a small processor core. It watches two active-low, level-sensitive request lines (a fast request and a normal request) and holds the current status word: a 5-bit mode field and three mask bits, one each for asynchronous aborts, normal interrupts and fast interrupts. It also holds a saved-status register and a link register for each of the two interrupt modes.

When an unmasked request is present at a clock edge, the unit saves the status word and the return address supplied by the core into the bank of the target mode. In the same edge it switches mode, sets the masks and emits the handler address together with a one-cycle load strobe. Software acts through two commands. The first is a mask command: it clears or sets named mask bits and can optionally write a new mode. The second is an exception return: it restores the status word and the PC from the bank of the current mode.

A fast-request non-maskable option is sampled while reset is held. The normal-interrupt handler address can be taken from an external vectoring controller instead of the fixed address.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst_ni` is low, the status word becomes `0x1D3` (mode 10011, A=F=I=1), `pc_o` becomes 0, `pc_load_o` becomes 0, and all banked registers become 0. The status word layout is mode in [4:0], F in bit 6, I in bit 7 and A in bit 8. Bit 5 reads 0.
- R2: `irq_ni` low is accepted only while I (bit 7) is 0, and `fiq_ni` low is accepted only while F (bit 6) is 0. A masked or high line has no effect on any output.
- R3: An accepted normal request does four things at the edge: the IRQ bank (mode 10010) stores the current status word and `cur_pc_i`; the mode becomes 10010; I is set; and `pc_o` becomes `0x18` while `vec_en_i` is 0. `pc_load_o` is high for the following cycle only.
- R4: An accepted fast request does four things at the edge: the FIQ bank (mode 10001) stores the status word and `cur_pc_i`; the mode becomes 10001; both F and I are set; and `pc_o` becomes `0x1C`.
- R5: When both requests are accepted in the same cycle, the fast request wins and the normal request is left pending.
- R6: With `vec_en_i` high, an accepted normal request loads `pc_o` from `vic_addr_i`. Fast entry always uses `0x1C`.
- R7: A mask command (`cps_valid_i`) names bits in `cps_aif_i`, with bit 2 = A, bit 1 = I and bit 0 = F. When `cps_enable_i` = 1 it clears the named bits; when `cps_enable_i` = 0 it sets them. Unnamed bits keep their value.
- R8: A mask command with `cps_mode_vld_i` high writes `cps_mode_i` into the mode field. Otherwise the mode is unchanged.
- R9: If `nmfiq_cfg_i` is high while reset is held, later mask commands cannot set F, but fast entry still sets F. Changes on `nmfiq_cfg_i` after reset have no effect.
- R10: `eret_i` in mode 10001 or 10010 copies that mode's saved status into the status word and its link register into `pc_o`, with a one-cycle `pc_load_o`. In any other mode it is ignored.
- R11: In a cycle that accepts a request, mask and return commands are discarded. In a cycle where `eret_i` is high, a mask command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmfiq_cfg_i | input | 1 | Fast-request non-maskable option, sampled during reset |
| fiq_ni | input | 1 | Fast interrupt request, active low, level |
| irq_ni | input | 1 | Normal interrupt request, active low, level |
| cur_pc_i | input | AW | Return address to save on entry |
| vec_en_i | input | 1 | Take normal handler address from `vic_addr_i` |
| vic_addr_i | input | AW | Handler address from external controller |
| cps_valid_i | input | 1 | Mask command strobe |
| cps_enable_i | input | 1 | 1 = clear named masks, 0 = set them |
| cps_aif_i | input | 3 | Named masks: [2]=A, [1]=I, [0]=F |
| cps_mode_vld_i | input | 1 | Mask command also writes mode |
| cps_mode_i | input | 5 | New mode value |
| eret_i | input | 1 | Exception return strobe |
| pc_o | output | AW | Next PC |
| pc_load_o | output | 1 | `pc_o` was updated this cycle |
| cpsr_o | output | 9 | Current status word |

## Verification
A wrong mask bit in the status word appears on `cpsr_o` one cycle after the command or entry that caused it. It also changes which later request is accepted, so the mismatch recurs as a wrong entry or a missing `pc_load_o`. A corrupted bank entry stays hidden until the next return from that mode. The return then shows both a wrong `cpsr_o` and a wrong `pc_o`, so the stimulus keeps returning from both interrupt modes often. A wrongly sampled non-maskable option shows only when a later command tries to set F, so both reset settings are exercised with such commands.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int SW     = 9;
  localparam int MODE_W = 5;
  localparam int F_BIT  = 6;
  localparam int I_BIT  = 7;
  localparam int A_BIT  = 8;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;

  localparam logic [31:0] VEC_IRQ = 32'h0000_0018;
  localparam logic [31:0] VEC_FIQ = 32'h0000_001C;

  localparam int NBANK    = 2;
  localparam int BANK_IW  = $clog2(NBANK);
  localparam logic [BANK_IW-1:0] BANK_FIQ = 1'b0;
  localparam logic [BANK_IW-1:0] BANK_IRQ = 1'b1;

  localparam logic [SW-1:0] CPSR_RESET = {3'b111, 1'b0, MODE_SVC};
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fiq_ni,
  input  logic irq_ni,
  input  logic f_mask_i,
  input  logic i_mask_i,
  output logic take_fiq_o,
  output logic take_irq_o
);
  logic fiq_req, irq_req;

  assign fiq_req    = !fiq_ni && !f_mask_i;
  assign irq_req    = !irq_ni && !i_mask_i;
  assign take_fiq_o = fiq_req;
  assign take_irq_o = irq_req && !fiq_req;

  assert_single_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_fiq_o && take_irq_o));
  assert_irq_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_mask_i |-> !take_irq_o);
  assert_fiq_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_mask_i |-> !take_fiq_o);
endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int NB = NBANK,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [SW-1:0] spsr_wr_i,
  input  logic [AW-1:0] lr_wr_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [SW-1:0] spsr_rd_o,
  output logic [AW-1:0] lr_rd_o
);
  logic [SW-1:0] spsr_q [NB];
  logic [AW-1:0] lr_q   [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        spsr_q[b] <= '0;
        lr_q[b]   <= '0;
      end else if (wr_i && wr_idx_i == IW'(b)) begin
        spsr_q[b] <= spsr_wr_i;
        lr_q[b]   <= lr_wr_i;
      end
    end
  end

  assign spsr_rd_o = spsr_q[rd_idx_i];
  assign lr_rd_o   = lr_q[rd_idx_i];

  assert_bank_save_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (spsr_q[$past(wr_idx_i)] == $past(spsr_wr_i)) &&
             (lr_q[$past(wr_idx_i)] == $past(lr_wr_i)));
endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nm_i,
  input  logic              take_fiq_i,
  input  logic              take_irq_i,
  input  logic              ret_i,
  input  logic [SW-1:0]     spsr_i,
  input  logic              cps_i,
  input  logic              cps_set_i,
  input  logic [2:0]        cps_aif_i,
  input  logic              cps_mode_vld_i,
  input  logic [MODE_W-1:0] cps_mode_i,
  output logic [SW-1:0]     cpsr_o
);
  logic [SW-1:0] cpsr_q, cpsr_d;

  always_comb begin
    cpsr_d = cpsr_q;
    if (take_fiq_i) begin
      cpsr_d[F_BIT]      = 1'b1;
      cpsr_d[I_BIT]      = 1'b1;
      cpsr_d[MODE_W-1:0] = MODE_FIQ;
    end else if (take_irq_i) begin
      cpsr_d[I_BIT]      = 1'b1;
      cpsr_d[MODE_W-1:0] = MODE_IRQ;
    end else if (ret_i) begin
      cpsr_d = spsr_i;
    end else if (cps_i) begin
      // aif[k] maps to status bit F_BIT+k
      for (int k = 0; k < 3; k++) begin
        if (cps_aif_i[k]) begin
          if (!cps_set_i)                 cpsr_d[F_BIT+k] = 1'b0;
          else if (!(k == 0 && nm_i))     cpsr_d[F_BIT+k] = 1'b1;
        end
      end
      if (cps_mode_vld_i) cpsr_d[MODE_W-1:0] = cps_mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpsr_q <= CPSR_RESET;
    else         cpsr_q <= cpsr_d;
  end

  assign cpsr_o = cpsr_q;

  assert_fiq_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_fiq_i |=> cpsr_q[MODE_W-1:0] == MODE_FIQ && cpsr_q[F_BIT] && cpsr_q[I_BIT]);
  assert_irq_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_i |=> cpsr_q[MODE_W-1:0] == MODE_IRQ && cpsr_q[I_BIT]
                   && cpsr_q[F_BIT] == $past(cpsr_q[F_BIT]));
  assert_nmfiq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nm_i && cps_i && !take_fiq_i && !take_irq_i && !ret_i && !cpsr_q[F_BIT]) |=> !cpsr_q[F_BIT]);
  assert_cps_mode_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cps_i && !cps_mode_vld_i && !take_fiq_i && !take_irq_i && !ret_i)
      |=> $stable(cpsr_q[MODE_W-1:0]));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmfiq_cfg_i,
  input  logic              fiq_ni,
  input  logic              irq_ni,
  input  logic [AW-1:0]     cur_pc_i,
  input  logic              vec_en_i,
  input  logic [AW-1:0]     vic_addr_i,
  input  logic              cps_valid_i,
  input  logic              cps_enable_i,
  input  logic [2:0]        cps_aif_i,
  input  logic              cps_mode_vld_i,
  input  logic [MODE_W-1:0] cps_mode_i,
  input  logic              eret_i,
  output logic [AW-1:0]     pc_o,
  output logic              pc_load_o,
  output logic [SW-1:0]     cpsr_o
);
  logic                nm_q;
  logic                take_fiq, take_irq, entry;
  logic                ret_hit, do_ret, do_cps;
  logic [BANK_IW-1:0]  rd_idx, wr_idx;
  logic [SW-1:0]       spsr_rd, cpsr;
  logic [AW-1:0]       lr_rd, pc_q;
  logic                load_q;

  // option latched only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) nm_q <= nmfiq_cfg_i;
  end

  exc_arbiter u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fiq_ni     (fiq_ni),
    .irq_ni     (irq_ni),
    .f_mask_i   (cpsr[F_BIT]),
    .i_mask_i   (cpsr[I_BIT]),
    .take_fiq_o (take_fiq),
    .take_irq_o (take_irq)
  );

  assign entry   = take_fiq || take_irq;
  assign ret_hit = (cpsr[MODE_W-1:0] == MODE_FIQ) || (cpsr[MODE_W-1:0] == MODE_IRQ);
  assign rd_idx  = (cpsr[MODE_W-1:0] == MODE_FIQ) ? BANK_FIQ : BANK_IRQ;
  assign wr_idx  = take_fiq ? BANK_FIQ : BANK_IRQ;
  assign do_ret  = eret_i && !entry && ret_hit;
  assign do_cps  = cps_valid_i && !entry && !eret_i;

  exc_bank #(.AW(AW), .NB(NBANK)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (entry),
    .wr_idx_i  (wr_idx),
    .spsr_wr_i (cpsr),
    .lr_wr_i   (cur_pc_i),
    .rd_idx_i  (rd_idx),
    .spsr_rd_o (spsr_rd),
    .lr_rd_o   (lr_rd)
  );

  exc_status u_stat (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .nm_i           (nm_q),
    .take_fiq_i     (take_fiq),
    .take_irq_i     (take_irq),
    .ret_i          (do_ret),
    .spsr_i         (spsr_rd),
    .cps_i          (do_cps),
    .cps_set_i      (!cps_enable_i),
    .cps_aif_i      (cps_aif_i),
    .cps_mode_vld_i (cps_mode_vld_i),
    .cps_mode_i     (cps_mode_i),
    .cpsr_o         (cpsr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= entry || do_ret;
      if (take_fiq)      pc_q <= AW'(VEC_FIQ);
      else if (take_irq) pc_q <= vec_en_i ? vic_addr_i : AW'(VEC_IRQ);
      else if (do_ret)   pc_q <= lr_rd;
    end
  end

  assign pc_o      = pc_q;
  assign pc_load_o = load_q;
  assign cpsr_o    = cpsr;

  assert_irq_fixed_vec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_irq && !vec_en_i) |=> pc_o == AW'(VEC_IRQ) && pc_load_o);
  assert_irq_vic_vec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_irq && vec_en_i) |=> pc_o == $past(vic_addr_i) && pc_load_o);
  assert_fiq_vec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_fiq |=> pc_o == AW'(VEC_FIQ) && pc_load_o);
  assert_ret_restore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_ret |=> cpsr_o == $past(spsr_rd) && pc_o == $past(lr_rd) && pc_load_o);
  assert_ret_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !ret_hit && !entry) |=> !pc_load_o && $stable(pc_o));
  assert_entry_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry && eret_i) |=> cpsr_o[MODE_W-1:0] == MODE_FIQ || cpsr_o[MODE_W-1:0] == MODE_IRQ);
endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          nmfiq_cfg_i, fiq_ni, irq_ni, vec_en_i;
  logic [AW-1:0] cur_pc_i, vic_addr_i;
  logic          cps_valid_i, cps_enable_i, cps_mode_vld_i, eret_i;
  logic [2:0]    cps_aif_i;
  logic [4:0]    cps_mode_i;
  logic [AW-1:0] pc_o;
  logic          pc_load_o;
  logic [8:0]    cpsr_o;

  exc_entry_unit #(.AW(AW)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic [8:0]    m_cpsr;
  logic [8:0]    m_spsr [2];
  logic [AW-1:0] m_lr [2];
  logic [AW-1:0] m_pc;
  logic          m_load, m_nm;
  string         m_tag;
  int            n_vec = 0, n_bad = 0;

  task automatic check_outputs();
    n_vec++;
    if (pc_o !== m_pc || pc_load_o !== m_load || cpsr_o !== m_cpsr) begin
      n_bad++;
      $display("FAIL %s: pc=%h load=%b cpsr=%h expected pc=%h load=%b cpsr=%h",
               m_tag, pc_o, pc_load_o, cpsr_o, m_pc, m_load, m_cpsr);
    end
  endtask

  // bank 0 = mode 10001, bank 1 = mode 10010
  task automatic model_step();
    logic fq, iq;
    int   bi;
    fq = !fiq_ni && !m_cpsr[6];
    iq = !irq_ni && !m_cpsr[7];
    m_load = 1'b0;
    if (fq) begin
      m_spsr[0] = m_cpsr; m_lr[0] = cur_pc_i;
      m_cpsr = {m_cpsr[8], 2'b11, m_cpsr[5], 5'b10001};
      m_pc = 32'h1C; m_load = 1'b1;
      m_tag = (cps_valid_i || eret_i) ? "R11" : (iq ? "R5" : "R4");
    end else if (iq) begin
      m_spsr[1] = m_cpsr; m_lr[1] = cur_pc_i;
      m_cpsr = {m_cpsr[8], 1'b1, m_cpsr[6], m_cpsr[5], 5'b10010};
      m_pc = vec_en_i ? vic_addr_i : 32'h18; m_load = 1'b1;
      m_tag = (cps_valid_i || eret_i) ? "R11" : (vec_en_i ? "R6" : "R3");
    end else if (eret_i) begin
      m_tag = "R10";
      if (m_cpsr[4:0] == 5'b10001 || m_cpsr[4:0] == 5'b10010) begin
        bi = (m_cpsr[4:0] == 5'b10001) ? 0 : 1;
        m_cpsr = m_spsr[bi]; m_pc = m_lr[bi]; m_load = 1'b1;
      end
      if (cps_valid_i) m_tag = "R11";
    end else if (cps_valid_i) begin
      m_tag = cps_mode_vld_i ? "R8" : "R7";
      for (int k = 0; k < 3; k++) begin
        if (cps_aif_i[k]) begin
          if (cps_enable_i) m_cpsr[6+k] = 1'b0;
          else if (k == 0 && m_nm) m_tag = "R9";
          else m_cpsr[6+k] = 1'b1;
        end
      end
      if (cps_mode_vld_i) m_cpsr[4:0] = cps_mode_i;
    end else begin
      m_tag = "R2";
    end
  endtask

  task automatic idle_inputs();
    fiq_ni = 1'b1; irq_ni = 1'b1; vec_en_i = 1'b0;
    cur_pc_i = '0; vic_addr_i = '0;
    cps_valid_i = 1'b0; cps_enable_i = 1'b0; cps_aif_i = '0;
    cps_mode_vld_i = 1'b0; cps_mode_i = '0; eret_i = 1'b0;
  endtask

  task automatic apply(input logic f, input logic i, input logic [AW-1:0] pcv,
                       input logic ve, input logic [AW-1:0] vic,
                       input logic cv, input logic ce, input logic [2:0] aif,
                       input logic mv, input logic [4:0] md, input logic er);
    fiq_ni = f; irq_ni = i; cur_pc_i = pcv; vec_en_i = ve; vic_addr_i = vic;
    cps_valid_i = cv; cps_enable_i = ce; cps_aif_i = aif;
    cps_mode_vld_i = mv; cps_mode_i = md; eret_i = er;
    model_step();
    @(negedge clk_i);
    check_outputs();
  endtask

  task automatic do_reset(input logic nm);
    idle_inputs();
    rst_ni = 1'b0; nmfiq_cfg_i = nm;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    m_cpsr = 9'h1D3; m_pc = '0; m_load = 1'b0; m_nm = nm;
    m_spsr[0] = '0; m_spsr[1] = '0; m_lr[0] = '0; m_lr[1] = '0;
    m_tag = "R1";
    check_outputs();
  endtask

  task automatic random_run(input int n, input logic wiggle_cfg);
    logic [4:0] modes [4];
    modes[0] = 5'b10001; modes[1] = 5'b10010; modes[2] = 5'b10011; modes[3] = 5'b10000;
    for (int v = 0; v < n; v++) begin
      if (wiggle_cfg) nmfiq_cfg_i = $urandom_range(0, 1) == 1;
      apply($urandom_range(0, 9) > 1, $urandom_range(0, 9) > 2, $urandom(),
            $urandom_range(0, 1) == 1, $urandom() & 32'hFFFF_FFFC,
            $urandom_range(0, 9) < 3, $urandom_range(0, 2) != 0, 3'($urandom_range(0, 7)),
            $urandom_range(0, 3) == 0, modes[$urandom_range(0, 3)],
            $urandom_range(0, 9) < 2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1 reset, R2 masked request
    do_reset(1'b0);
    apply(1'b1, 1'b0, 32'h100, 0, 0, 0, 0, 0, 0, 0, 0);  // R2 irq masked
    apply(1'b0, 1'b1, 32'h104, 0, 0, 0, 0, 0, 0, 0, 0);  // R2 fiq masked
    apply(1'b1, 1'b1, 0, 0, 0, 1, 1, 3'b011, 0, 0, 0);    // R7 clear I,F
    apply(1'b0, 1'b0, 32'h200, 0, 0, 0, 0, 0, 0, 0, 0);  // R5 both, fiq wins
    apply(1'b1, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1);        // R10 return from fiq
    apply(1'b1, 1'b0, 32'h300, 0, 0, 0, 0, 0, 0, 0, 0);  // R3 fixed vector
    apply(1'b1, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1);        // R10
    apply(1'b1, 1'b0, 32'h400, 0, 0, 1, 0, 3'b111, 1, 5'b10000, 0); // R11 entry drops cps
    apply(1'b1, 1'b1, 0, 0, 0, 1, 0, 3'b100, 0, 0, 1);   // R11 eret drops cps
    apply(1'b1, 1'b0, 32'h500, 1, 32'h8000, 0, 0, 0, 0, 0, 0); // R6 vectored
    apply(1'b1, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    apply(1'b1, 1'b1, 0, 0, 0, 1, 0, 3'b100, 1, 5'b10000, 0); // R8 mode change
    apply(1'b1, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1);        // R10 ignored
    apply(1'b1, 1'b1, 0, 0, 0, 1, 0, 3'b001, 0, 0, 0);   // R7 set F
    apply(1'b1, 1'b1, 0, 0, 0, 1, 1, 3'b001, 1, 5'b10011, 0);
    random_run(3000, 1'b0);
    // R9 non-maskable fast request
    do_reset(1'b1);
    nmfiq_cfg_i = 1'b0;
    apply(1'b1, 1'b1, 0, 0, 0, 1, 1, 3'b011, 0, 0, 0);
    apply(1'b1, 1'b1, 0, 0, 0, 1, 0, 3'b001, 0, 0, 0);   // R9 F stays clear
    apply(1'b0, 1'b1, 32'h600, 0, 0, 0, 0, 0, 0, 0, 0);  // R4 F set by entry
    apply(1'b1, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    random_run(3000, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule